// File: doc/BRIEF.md
# Serial/Infrared Logical Device Configuration Registers

This block is the configuration register set for one serial or infrared logical device in a super I/O controller. Software reaches it through an index/data configuration port: an 8-bit index selects a register, an 8-bit data byte is written on a strobe at the clock edge, and the read byte for the selected index is presented combinationally. The registers hold an activate bit, a 16-bit I/O base address, an interrupt number and type, receive and transmit DMA channel selects, and a device configuration byte that controls power mode, output release and bank switching.

From the stored settings the block derives the control signals the serial/infrared datapath and its pad ring need. These are a device-enabled flag, a gated clock enable, a flag that parks outputs at their idle levels, a pad output enable, a forced-low request for the transmit pin, and a runtime select for bus cycles that hit the programmed base address. The datapath supplies only a busy flag, which reads back in the configuration byte.

Top module: `sioLdevCfg`

## Requirements
- R1: After reset, the read data is 00h at index 30h, 03h at 60h, E8h at 61h, 00h at 70h, 03h at 71h, 04h at 74h, 04h at 75h and 02h at F0h (busy input low). Read data follows the index combinationally.
- R2: Any index other than the eight listed in R1 reads 00h. Writes to such an index change no register.
- R3: At index 30h only bit 0 (activate) is writable, and bits 7:1 read 0. `devEnable` is high exactly when the activate bit is 1 and `globalEn` is high.
- R4: Index 60h holds base address bits 15:8, with bits 7:3 read-only 0. Index 61h holds base address bits 7:0, with bits 2:0 read-only 0. `baseAddr` shows the combined value.
- R5: At index 71h only bit 1 is writable. Bit 0 always reads 1 and bits 7:2 always read 0.
- R6: Indices 70h, 74h and 75h are fully writable 8-bit registers, shown on `irqNum`, `rxDmaSel` and `txDmaSel`.
- R7: At index F0h, bit 2 reads the `devBusy` input and ignores writes. Bits 6:3 read 0. Bits 7, 1 and 0 are writable.
- R8: `devClkEn` is high exactly when `devEnable` is high and F0h bit 1 (power mode) is 1. `pinsIdle` is the inverse of `devClkEn`. In low-power mode all registers keep their contents and remain writable.
- R9: `pinOe` is low exactly when the device is not enabled and F0h bit 0 (release control) is 1. Low-power mode alone never releases the pads.
- R10: `txForceLow` is high whenever the device is not enabled, whatever the release control bit holds.
- R11: `rtSelect` is high exactly when `devEnable` is high and `busAddr` matches `baseAddr` once bits 2:0 of both are ignored.
- R12: `bankSwitchEn` equals F0h bit 7. `extSelect` is high exactly when `rtSelect` and `bankSwitchEn` are both high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| cfgIndex | input | 8 | Configuration register index |
| cfgWrData | input | 8 | Configuration write data |
| cfgWrEn | input | 1 | Write strobe, sampled at the clock edge |
| cfgRdData | output | 8 | Read data for the selected index |
| globalEn | input | 1 | Controller-wide enable for this device |
| devBusy | input | 1 | Transfer-in-progress flag from the datapath |
| busAddr | input | 16 | Runtime bus I/O address |
| devEnable | output | 1 | Device enabled (activate bit and global enable) |
| devClkEn | output | 1 | Clock enable for the datapath |
| pinsIdle | output | 1 | Hold device outputs at their idle levels |
| pinOe | output | 1 | Pad output enable for device outputs except transmit |
| txForceLow | output | 1 | Drive the transmit pin to 0 |
| rtSelect | output | 1 | Bus address hits the device's runtime window |
| extSelect | output | 1 | Runtime hit with bank switching allowed |
| bankSwitchEn | output | 1 | Bank switching enable |
| baseAddr | output | 16 | Programmed I/O base address |
| irqNum | output | 8 | Interrupt number |
| irqType | output | 8 | Interrupt type byte |
| rxDmaSel | output | 8 | Receive DMA channel select |
| txDmaSel | output | 8 | Transmit DMA channel select |

## Verification
The assertions assume `cfgIndex` and `busAddr` are stable around the sampling edge. They also assume `devBusy` is a plain level input that needs no protocol. The relations they check are implications between ports that must hold in every state. The stimulus changes the index, the data, the strobe and the mode inputs only on the falling clock edge, so each value is settled at the rising edge where registers load and assertions sample. Busy is held at a fixed level through each sweep, except in the one test that toggles it to check the readback.

// File: rtl/sioLdevPkg.sv
package sioLdevPkg;

  localparam int NSLOT       = 8;
  localparam int DATA_W      = 8;
  localparam int ADDR_W      = 16;
  localparam int BASE_ALIGN  = 3;   // low address bits ignored by the window
  localparam int BASE_TOP    = 11;  // address bits at and above this are fixed 0

  localparam int SLOT_ACT    = 0;
  localparam int SLOT_BASEHI = 1;
  localparam int SLOT_BASELO = 2;
  localparam int SLOT_IRQ    = 3;
  localparam int SLOT_ITYPE  = 4;
  localparam int SLOT_RXDMA  = 5;
  localparam int SLOT_TXDMA  = 6;
  localparam int SLOT_CFG    = 7;

  localparam int CFG_BANK_BIT = 7;
  localparam int CFG_BUSY_BIT = 2;
  localparam int CFG_PWR_BIT  = 1;
  localparam int CFG_TRI_BIT  = 0;

  typedef struct packed {
    logic [NSLOT-1:0] rdHit;
    logic [NSLOT-1:0] wrHit;
  } cfgStrobe_t;

  function automatic logic [DATA_W-1:0] slotIndex(input int s);
    case (s)
      SLOT_ACT:    return 8'h30;
      SLOT_BASEHI: return 8'h60;
      SLOT_BASELO: return 8'h61;
      SLOT_IRQ:    return 8'h70;
      SLOT_ITYPE:  return 8'h71;
      SLOT_RXDMA:  return 8'h74;
      SLOT_TXDMA:  return 8'h75;
      default:     return 8'hF0;
    endcase
  endfunction

  function automatic logic [DATA_W-1:0] slotWrMask(input int s);
    case (s)
      SLOT_ACT:    return 8'h01;
      SLOT_BASEHI: return DATA_W'((1 << (BASE_TOP - DATA_W)) - 1);
      SLOT_BASELO: return DATA_W'(8'hFF << BASE_ALIGN);
      SLOT_ITYPE:  return 8'h02;
      SLOT_CFG:    return DATA_W'((1 << CFG_BANK_BIT) | (1 << CFG_PWR_BIT) | (1 << CFG_TRI_BIT));
      default:     return 8'hFF;
    endcase
  endfunction

  function automatic logic [DATA_W-1:0] slotReset(input int s);
    case (s)
      SLOT_BASEHI: return 8'h03;
      SLOT_BASELO: return 8'hE8;
      SLOT_ITYPE:  return 8'h03;
      SLOT_RXDMA:  return 8'h04;
      SLOT_TXDMA:  return 8'h04;
      SLOT_CFG:    return 8'h02;
      default:     return 8'h00;
    endcase
  endfunction

endpackage

// File: rtl/sioLdevCtrl.sv
module sioLdevCtrl
  import sioLdevPkg::*;
#(
  parameter int AW      = ADDR_W,
  parameter int ALIGN_W = BASE_ALIGN
) (
  input  logic [DATA_W-1:0] cfgIndex,
  input  logic              cfgWrEn,
  output cfgStrobe_t        strobe,
  input  logic              actBit,
  input  logic              globalEn,
  input  logic              pwrMode,
  input  logic              triCtl,
  input  logic              bankBit,
  input  logic [AW-1:0]     baseAddr,
  input  logic [AW-1:0]     busAddr,
  output logic              devEnable,
  output logic              devClkEn,
  output logic              pinsIdle,
  output logic              pinOe,
  output logic              txForceLow,
  output logic              rtSelect,
  output logic              extSelect,
  output logic              bankSwitchEn
);

  localparam logic [AW-1:0] WIN_MASK = ~AW'((1 << ALIGN_W) - 1);

  logic [NSLOT-1:0] hit;
  logic             winMatch;

  // One comparator per implemented index.
  for (genvar s = 0; s < NSLOT; s++) begin : gDecode
    assign hit[s] = (cfgIndex == slotIndex(s));
  end

  always_comb begin
    strobe.rdHit = hit;
    strobe.wrHit = cfgWrEn ? hit : '0;
  end

  // Enable chain: activation gates everything, power mode gates the clock.
  assign devEnable    = actBit & globalEn;
  assign devClkEn     = devEnable & pwrMode;
  assign pinsIdle     = ~devClkEn;

  // Pads are released only on deactivation with release control set;
  // the transmit pin is driven low whenever the device is not enabled.
  assign pinOe        = devEnable | ~triCtl;
  assign txForceLow   = ~devEnable;

  // Runtime window: aligned block at the programmed base.
  assign winMatch     = ((busAddr & WIN_MASK) == (baseAddr & WIN_MASK));
  assign rtSelect     = devEnable & winMatch;
  assign bankSwitchEn = bankBit;
  assign extSelect    = rtSelect & bankBit;

endmodule

// File: rtl/sioLdevRegs.sv
module sioLdevRegs
  import sioLdevPkg::*;
(
  input  logic                          clk,
  input  logic                          rstN,
  input  cfgStrobe_t                    strobe,
  input  logic [DATA_W-1:0]             wrData,
  input  logic                          devBusy,
  output logic [NSLOT-1:0][DATA_W-1:0]  regQ,
  output logic [DATA_W-1:0]             rdData
);

  logic [NSLOT-1:0][DATA_W-1:0] regView;

  for (genvar s = 0; s < NSLOT; s++) begin : gSlot
    localparam logic [DATA_W-1:0] WMASK = slotWrMask(s);
    localparam logic [DATA_W-1:0] RVAL  = slotReset(s);

    logic [DATA_W-1:0] slotQ;

    // Read-only bits keep their reset value; only masked bits load.
    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) begin
        slotQ <= RVAL;
      end else if (strobe.wrHit[s]) begin
        slotQ <= (slotQ & ~WMASK) | (wrData & WMASK);
      end
    end

    assign regQ[s] = slotQ;

    if (s == SLOT_CFG) begin : gLive
      assign regView[s] = slotQ | (DATA_W'(devBusy) << CFG_BUSY_BIT);
    end else begin : gPlain
      assign regView[s] = slotQ;
    end
  end

  // Indices are distinct, so an OR of the selected views forms the mux;
  // an unimplemented index selects nothing and reads zero.
  always_comb begin
    rdData = '0;
    for (int s = 0; s < NSLOT; s++) begin
      if (strobe.rdHit[s]) rdData = rdData | regView[s];
    end
  end

endmodule

// File: rtl/sioLdevCfg.sv
module sioLdevCfg
  import sioLdevPkg::*;
(
  input  logic        clk,
  input  logic        rstN,
  input  logic [7:0]  cfgIndex,
  input  logic [7:0]  cfgWrData,
  input  logic        cfgWrEn,
  output logic [7:0]  cfgRdData,
  input  logic        globalEn,
  input  logic        devBusy,
  input  logic [15:0] busAddr,
  output logic        devEnable,
  output logic        devClkEn,
  output logic        pinsIdle,
  output logic        pinOe,
  output logic        txForceLow,
  output logic        rtSelect,
  output logic        extSelect,
  output logic        bankSwitchEn,
  output logic [15:0] baseAddr,
  output logic [7:0]  irqNum,
  output logic [7:0]  irqType,
  output logic [7:0]  rxDmaSel,
  output logic [7:0]  txDmaSel
);

  cfgStrobe_t                   strobe;
  logic [NSLOT-1:0][DATA_W-1:0] regQ;
  logic [DATA_W-2:0]            unusedActBits;
  logic [3:0]                   unusedCfgBits;

  sioLdevRegs uRegs (
    .clk    (clk),
    .rstN   (rstN),
    .strobe (strobe),
    .wrData (cfgWrData),
    .devBusy(devBusy),
    .regQ   (regQ),
    .rdData (cfgRdData)
  );

  assign baseAddr      = {regQ[SLOT_BASEHI], regQ[SLOT_BASELO]};
  assign irqNum        = regQ[SLOT_IRQ];
  assign irqType       = regQ[SLOT_ITYPE];
  assign rxDmaSel      = regQ[SLOT_RXDMA];
  assign txDmaSel      = regQ[SLOT_TXDMA];
  assign unusedActBits = regQ[SLOT_ACT][DATA_W-1:1];
  assign unusedCfgBits = regQ[SLOT_CFG][6:3];

  sioLdevCtrl #(.AW(ADDR_W), .ALIGN_W(BASE_ALIGN)) uCtrl (
    .cfgIndex    (cfgIndex),
    .cfgWrEn     (cfgWrEn),
    .strobe      (strobe),
    .actBit      (regQ[SLOT_ACT][0]),
    .globalEn    (globalEn),
    .pwrMode     (regQ[SLOT_CFG][CFG_PWR_BIT]),
    .triCtl      (regQ[SLOT_CFG][CFG_TRI_BIT]),
    .bankBit     (regQ[SLOT_CFG][CFG_BANK_BIT]),
    .baseAddr    (baseAddr),
    .busAddr     (busAddr),
    .devEnable   (devEnable),
    .devClkEn    (devClkEn),
    .pinsIdle    (pinsIdle),
    .pinOe       (pinOe),
    .txForceLow  (txForceLow),
    .rtSelect    (rtSelect),
    .extSelect   (extSelect),
    .bankSwitchEn(bankSwitchEn)
  );

endmodule

// File: rtl/sioLdevChk.sv
module sioLdevChk (
  input logic        clk,
  input logic        rstN,
  input logic [7:0]  cfgIndex,
  input logic [7:0]  cfgRdData,
  input logic        globalEn,
  input logic        devBusy,
  input logic [15:0] busAddr,
  input logic [15:0] baseAddr,
  input logic        devEnable,
  input logic        devClkEn,
  input logic        pinsIdle,
  input logic        pinOe,
  input logic        txForceLow,
  input logic        rtSelect,
  input logic        extSelect,
  input logic        bankSwitchEn
);

  logic knownIdx;
  always_comb begin
    case (cfgIndex)
      8'h30, 8'h60, 8'h61, 8'h70, 8'h71, 8'h74, 8'h75, 8'hF0: knownIdx = 1'b1;
      default: knownIdx = 1'b0;
    endcase
  end

  assert_unknown_zero_R2: assert property (@(posedge clk) disable iff (!rstN)
    !knownIdx |-> cfgRdData == 8'h00);

  assert_act_gated_R3: assert property (@(posedge clk) disable iff (!rstN)
    devEnable |-> globalEn);

  assert_act_upper_R3: assert property (@(posedge clk) disable iff (!rstN)
    (cfgIndex == 8'h30) |-> cfgRdData[7:1] == 7'd0);

  assert_base_hi_ro_R4: assert property (@(posedge clk) disable iff (!rstN)
    (cfgIndex == 8'h60) |-> cfgRdData[7:3] == 5'd0);

  assert_base_lo_ro_R4: assert property (@(posedge clk) disable iff (!rstN)
    (cfgIndex == 8'h61) |-> cfgRdData[2:0] == 3'd0);

  assert_base_align_R4: assert property (@(posedge clk) disable iff (!rstN)
    baseAddr[15:11] == 5'd0 && baseAddr[2:0] == 3'd0);

  assert_itype_fixed_R5: assert property (@(posedge clk) disable iff (!rstN)
    (cfgIndex == 8'h71) |-> (cfgRdData[0] && cfgRdData[7:2] == 6'd0));

  assert_busy_view_R7: assert property (@(posedge clk) disable iff (!rstN)
    (cfgIndex == 8'hF0) |-> (cfgRdData[2] == devBusy && cfgRdData[6:3] == 4'd0));

  assert_clk_needs_enable_R8: assert property (@(posedge clk) disable iff (!rstN)
    devClkEn |-> (devEnable && !pinsIdle));

  assert_release_inactive_R9: assert property (@(posedge clk) disable iff (!rstN)
    !pinOe |-> !devEnable);

  assert_tx_low_R10: assert property (@(posedge clk) disable iff (!rstN)
    !devEnable |-> txForceLow);

  assert_window_R11: assert property (@(posedge clk) disable iff (!rstN)
    rtSelect |-> (devEnable && busAddr[15:3] == baseAddr[15:3]));

  assert_ext_R12: assert property (@(posedge clk) disable iff (!rstN)
    extSelect |-> (rtSelect && bankSwitchEn));

endmodule

bind sioLdevCfg sioLdevChk uChk (
  .clk         (clk),
  .rstN        (rstN),
  .cfgIndex    (cfgIndex),
  .cfgRdData   (cfgRdData),
  .globalEn    (globalEn),
  .devBusy     (devBusy),
  .busAddr     (busAddr),
  .baseAddr    (baseAddr),
  .devEnable   (devEnable),
  .devClkEn    (devClkEn),
  .pinsIdle    (pinsIdle),
  .pinOe       (pinOe),
  .txForceLow  (txForceLow),
  .rtSelect    (rtSelect),
  .extSelect   (extSelect),
  .bankSwitchEn(bankSwitchEn)
);

// File: tb/sim_sioLdevCfg.sv
`timescale 1ns/1ps
module sim_sioLdevCfg;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic [7:0]  cfgIndex = 8'h00;
  logic [7:0]  cfgWrData = 8'h00;
  logic        cfgWrEn = 1'b0;
  logic [7:0]  cfgRdData;
  logic        globalEn = 1'b0;
  logic        devBusy = 1'b0;
  logic [15:0] busAddr = 16'h0000;
  logic        devEnable, devClkEn, pinsIdle, pinOe, txForceLow;
  logic        rtSelect, extSelect, bankSwitchEn;
  logic [15:0] baseAddr;
  logic [7:0]  irqNum, irqType, rxDmaSel, txDmaSel;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  logic [7:0] model [256];

  always #10 clk = ~clk;

  sioLdevCfg u0 (
    .clk(clk), .rstN(rstN), .cfgIndex(cfgIndex), .cfgWrData(cfgWrData),
    .cfgWrEn(cfgWrEn), .cfgRdData(cfgRdData), .globalEn(globalEn),
    .devBusy(devBusy), .busAddr(busAddr), .devEnable(devEnable),
    .devClkEn(devClkEn), .pinsIdle(pinsIdle), .pinOe(pinOe),
    .txForceLow(txForceLow), .rtSelect(rtSelect), .extSelect(extSelect),
    .bankSwitchEn(bankSwitchEn), .baseAddr(baseAddr), .irqNum(irqNum),
    .irqType(irqType), .rxDmaSel(rxDmaSel), .txDmaSel(txDmaSel)
  );

  function automatic bit isImpl(input logic [7:0] i);
    return i == 8'h30 || i == 8'h60 || i == 8'h61 || i == 8'h70 ||
           i == 8'h71 || i == 8'h74 || i == 8'h75 || i == 8'hF0;
  endfunction

  function automatic logic [7:0] benchMask(input logic [7:0] i);
    case (i)
      8'h30: return 8'b0000_0001;
      8'h60: return 8'b0000_0111;
      8'h61: return 8'b1111_1000;
      8'h71: return 8'b0000_0010;
      8'hF0: return 8'b1000_0011;
      8'h70, 8'h74, 8'h75: return 8'hFF;
      default: return 8'h00;
    endcase
  endfunction

  function automatic string reqOf(input logic [7:0] i);
    case (i)
      8'h30: return "R3";
      8'h60, 8'h61: return "R4";
      8'h71: return "R5";
      8'hF0: return "R7";
      8'h70, 8'h74, 8'h75: return "R6";
      default: return "R2";
    endcase
  endfunction

  function automatic logic [7:0] expRead(input logic [7:0] i);
    if (!isImpl(i)) return 8'h00;
    if (i == 8'hF0) return model[i] | (devBusy ? 8'h04 : 8'h00);
    return model[i];
  endfunction

  task automatic check(input string req, input string what, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  task automatic wr(input logic [7:0] i, input logic [7:0] d);
    @(negedge clk);
    cfgIndex = i; cfgWrData = d; cfgWrEn = 1'b1;
    @(negedge clk);
    cfgWrEn = 1'b0;
    if (isImpl(i)) model[i] = (model[i] & ~benchMask(i)) | (d & benchMask(i));
  endtask

  task automatic rdCheck(input logic [7:0] i, input string req);
    cfgIndex = i;
    #1;
    check(req, $sformatf("read idx %02h", i), 32'(cfgRdData), 32'(expRead(i)));
  endtask

  task automatic finishRun;
    if (!done) begin
      done = 1'b1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  endtask

  initial begin
    #(64'd20 * 64'd190000);
    checks++; errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    finishRun();
  end

  initial begin
    for (int i = 0; i < 256; i++) model[i] = 8'h00;
    model[8'h60] = 8'h03; model[8'h61] = 8'hE8; model[8'h71] = 8'h03;
    model[8'h74] = 8'h04; model[8'h75] = 8'h04; model[8'hF0] = 8'h02;

    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);

    // R1, R2: reset contents over the whole index space.
    for (int i = 0; i < 256; i++) rdCheck(8'(i), isImpl(8'(i)) ? "R1" : "R2");
    check("R1", "reset devEnable", 32'(devEnable), 0);
    check("R10", "reset txForceLow", 32'(txForceLow), 1);
    check("R9", "reset pinOe", 32'(pinOe), 1);

    // R3..R7: every data value into every implemented index.
    for (int i = 0; i < 256; i++) begin
      if (isImpl(8'(i))) begin
        for (int d = 0; d < 256; d++) begin
          wr(8'(i), 8'(d));
          rdCheck(8'(i), reqOf(8'(i)));
        end
      end
    end
    check("R4", "baseAddr port", 32'(baseAddr), 32'({model[8'h60], model[8'h61]}));
    check("R6", "irqNum port", 32'(irqNum), 32'(model[8'h70]));
    check("R6", "rxDmaSel port", 32'(rxDmaSel), 32'(model[8'h74]));
    check("R6", "txDmaSel port", 32'(txDmaSel), 32'(model[8'h75]));
    check("R5", "irqType port", 32'(irqType), 32'(model[8'h71]));

    // R2: writes to unimplemented indices leave all registers alone.
    wr(8'h70, 8'h3C); wr(8'h74, 8'h11); wr(8'h75, 8'h22);
    for (int i = 0; i < 256; i++) begin
      if (!isImpl(8'(i))) begin
        wr(8'(i), 8'hFF - 8'(i));
        rdCheck(8'(i), "R2");
      end
    end
    for (int i = 0; i < 256; i++) if (isImpl(8'(i))) rdCheck(8'(i), "R2");

    // R7: busy is live and write-proof.
    @(negedge clk); devBusy = 1'b1;
    rdCheck(8'hF0, "R7");
    wr(8'hF0, 8'h00);
    rdCheck(8'hF0, "R7");
    @(negedge clk); devBusy = 1'b0;
    rdCheck(8'hF0, "R7");

    // R3, R8, R9, R10, R12: all combinations of the control inputs.
    for (int c = 0; c < 32; c++) begin
      logic a, g, p, t, b, en;
      a = c[0]; g = c[1]; p = c[2]; t = c[3]; b = c[4];
      wr(8'h30, {7'd0, a});
      wr(8'hF0, {b, 5'd0, p, t});
      @(negedge clk); globalEn = g;
      #1;
      en = a & g;
      check("R3", "devEnable", 32'(devEnable), 32'(en));
      check("R8", "devClkEn", 32'(devClkEn), 32'(en & p));
      check("R8", "pinsIdle", 32'(pinsIdle), 32'(!(en & p)));
      check("R9", "pinOe", 32'(pinOe), 32'(en | !t));
      check("R10", "txForceLow", 32'(txForceLow), 32'(!en));
      check("R12", "bankSwitchEn", 32'(bankSwitchEn), 32'(b));
      if (!p) begin
        wr(8'h70, 8'(c) ^ 8'h5A);
        rdCheck(8'h70, "R8");
        rdCheck(8'h74, "R8");
      end
    end

    // R11, R12: runtime window around a new base.
    wr(8'h60, 8'h02); wr(8'h61, 8'h48);
    check("R4", "baseAddr new", 32'(baseAddr), 32'h0248);
    for (int m = 0; m < 4; m++) begin
      logic act, bk;
      act = m[0]; bk = m[1];
      wr(8'h30, {7'd0, act});
      wr(8'hF0, {bk, 7'b0000010});
      @(negedge clk); globalEn = 1'b1;
      for (int x = 0; x < 512; x++) begin
        logic [15:0] ad;
        logic hitExp;
        ad = 16'h0100 + 16'(x);
        busAddr = ad;
        #1;
        hitExp = act && (ad >= 16'h0248) && (ad <= 16'h024F);
        check("R11", $sformatf("rtSelect @%04h", ad), 32'(rtSelect), 32'(hitExp));
        check("R12", $sformatf("extSelect @%04h", ad), 32'(extSelect), 32'(hitExp & bk));
      end
      busAddr = 16'h8248; #1;
      check("R11", "rtSelect high alias", 32'(rtSelect), 0);
    end

    finishRun();
  end

endmodule